// File: doc/BRIEF.md
# Half-Duplex Transmit Controller

This block decides when each frame may go onto a shared, half-duplex Ethernet medium. It takes frame data beats from an upstream buffer and presents them on a byte or nibble transmit path. Before it sends anything it waits for carrier sense to clear. It then keeps the line quiet for the inter-frame gap. If the gap is broken by new carrier, it defers again.

If a collision is seen while data is going out, the controller keeps driving the data register for the length of a jam sequence. It then waits a random number of slot times and tries again. The random window is truncated binary exponential backoff. After a set number of collided attempts the frame is abandoned and flagged. The upstream buffer rewinds the frame whenever it sees the collision. If the buffer runs dry in the middle of a frame, the same jam path is used to end the frame with the error line asserted, which corrupts the frame check. There is no retry in that case.

An optional back-pressure mode forces a collision on every incoming frame. It does this by driving a fixed pattern as soon as carrier rises while the controller is idle. The frame check sequence is supplied by the upstream buffer as ordinary data.

Top module: `hdtx_mac_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, tx_en_o, tx_er_o, data_rd_o, done_o, excess_col_o and underrun_o are all low.
- R2: With a frame requested, tx_en_o stays low while crs_i is high. The first data beat appears on txd_o with tx_en_o high exactly IFG_BITS/DATA_W + 1 clock edges after the first edge that samples crs_i low. From idle with crs_i already low, this takes one edge more.
- R3: If crs_i is sampled high during the inter-frame gap, the gap restarts in full from the next edge that samples crs_i low.
- R4: Each beat accepted with data_rd_o high appears on txd_o, with tx_en_o high and tx_er_o low, on the following cycle, in order and with no holes. done_o is high for one cycle together with the beat that was accepted with data_last_i high.
- R5: A collision (col_i sampled high while beats are being sent) produces JAM_BITS/DATA_W cycles of tx_en_o high, starting on the cycle after the collision edge. During these cycles txd_o holds the last data beat and tx_er_o stays low.
- R6: After collision number n, tx_en_o stays low for exactly r*SLOT_BITS/DATA_W + IFG_BITS/DATA_W + 2 cycles before the retry starts. r is an integer with 0 <= r <= 2^min(n,BACKOFF_LIMIT) - 1.
- R7: When the MAX_ATTEMPTS-th attempt of one frame collides, excess_col_o is high for one cycle together with the last jam beat. No further attempt of that frame is made.
- R8: If data_avail_i is low while a frame is being sent, the controller drives JAM_BITS/DATA_W cycles with tx_en_o and tx_er_o high and txd_o holding the last data beat. underrun_o is high together with the last of these cycles. No retry follows and done_o stays low.
- R9: With bp_en_i high, no frame requested and the controller idle, a rising edge on crs_i makes it drive BP_BITS/DATA_W beats of BP_PATTERN, least significant beat first. The beats start on the second cycle after the edge that samples crs_i high.
- R10: With bp_en_i low, a rising crs_i while idle produces no transmission.
- R11: The collision count starts from zero for every new frame, so the first collision of any frame uses a backoff window of r in {0,1}.
- R12: done_o, excess_col_o and underrun_o are one-cycle pulses, at most one of them high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one data beat per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_i | input | 1 | A frame is waiting upstream; held until a status pulse |
| data_i | input | DATA_W | Current data beat from upstream |
| data_avail_i | input | 1 | data_i is valid; low during a frame means underrun |
| data_last_i | input | 1 | data_i is the final beat of the frame |
| data_rd_o | output | 1 | The beat on data_i is taken at this edge |
| crs_i | input | 1 | Carrier sense from the medium |
| col_i | input | 1 | Collision detect from the medium |
| bp_en_i | input | 1 | Enable forced collisions on incoming frames |
| txd_o | output | DATA_W | Transmit data beat |
| tx_en_o | output | 1 | Transmit enable |
| tx_er_o | output | 1 | Transmit error, marks an underrun-corrupted frame end |
| done_o | output | 1 | Frame sent successfully |
| excess_col_o | output | 1 | Frame abandoned after too many collisions |
| underrun_o | output | 1 | Frame ended early by an underrun |

## Verification
The assertions take for granted that col_i matters only while data beats are going out. They also assume the requester stops asking for a frame once a status pulse has been seen, so that two frame endings never fall closer than a full inter-frame gap apart. The stimulus keeps to this. It raises col_i for a single cycle, only after the data phase has begun. It holds crs_i low across every backoff, so retry gaps stay a pure function of the random slot count. It drops tx_req_i on the very cycle that done_o, excess_col_o or underrun_o is observed. Back-pressure stimulus is applied only while no frame is requested.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_IFG,
    ST_TX,
    ST_JAM,
    ST_BACKOFF,
    ST_BP
  } hdtx_state_e;
endpackage

// File: rtl/hdtx_lfsr.sv
module hdtx_lfsr #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    TAPS  = 16'hB400,
  parameter int              OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  // free-running Galois form, never reaches zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= W'(1);
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else           q <= q >> 1;
  end

  assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/hdtx_backoff.sv
module hdtx_backoff #(
  parameter int SLOT_BEATS = 128,
  parameter int LIMIT      = 10,
  parameter int ATT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ATT_W-1:0] att_i,
  input  logic [LIMIT-1:0] rnd_i,
  output logic             expire_o
);
  localparam int BW = (SLOT_BEATS > 1) ? $clog2(SLOT_BEATS) : 1;
  localparam logic [BW-1:0] BEAT_LD = BW'(SLOT_BEATS - 1);

  logic [LIMIT-1:0] mask;
  logic [LIMIT-1:0] slots_q;
  logic [BW-1:0]    beat_q;

  // window of 2^min(n,LIMIT) values
  always_comb begin
    for (int i = 0; i < LIMIT; i++) mask[i] = (int'(att_i) > i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      beat_q  <= '0;
    end else if (start_i) begin
      slots_q <= rnd_i & mask;
      beat_q  <= BEAT_LD;
    end else if (slots_q != '0) begin
      if (beat_q == '0) begin
        slots_q <= slots_q - 1'b1;
        beat_q  <= BEAT_LD;
      end else begin
        beat_q <= beat_q - 1'b1;
      end
    end
  end

  assign expire_o = (slots_q == '0);
endmodule

// File: rtl/hdtx_pattern_mux.sv
module hdtx_pattern_mux #(
  parameter int                  DATA_W  = 4,
  parameter int                  BITS    = 64,
  parameter logic [BITS-1:0]     PATTERN = '0,
  parameter int                  IDX_W   = 6
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] beat_o
);
  localparam int BEATS = BITS / DATA_W;

  always_comb begin
    beat_o = '0;
    for (int i = 0; i < BEATS; i++) begin
      if (idx_i == IDX_W'(i)) beat_o = PATTERN[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hdtx_mac_ctrl.sv
module hdtx_mac_ctrl import hdtx_pkg::*; #(
  parameter int                 DATA_W        = 4,
  parameter int                 IFG_BITS      = 96,
  parameter int                 JAM_BITS      = 32,
  parameter int                 SLOT_BITS     = 512,
  parameter int                 BP_BITS       = 64,
  parameter logic [BP_BITS-1:0] BP_PATTERN    = {(BP_BITS/8){8'hAA}},
  parameter int                 MAX_ATTEMPTS  = 16,
  parameter int                 BACKOFF_LIMIT = 10,
  parameter int                 LFSR_W        = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS     = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_avail_i,
  input  logic              data_last_i,
  output logic              data_rd_o,
  input  logic              crs_i,
  input  logic              col_i,
  input  logic              bp_en_i,
  output logic [DATA_W-1:0] txd_o,
  output logic              tx_en_o,
  output logic              tx_er_o,
  output logic              done_o,
  output logic              excess_col_o,
  output logic              underrun_o
);
  localparam int IFG_BEATS  = IFG_BITS / DATA_W;
  localparam int JAM_BEATS  = JAM_BITS / DATA_W;
  localparam int SLOT_BEATS = SLOT_BITS / DATA_W;
  localparam int BP_BEATS   = BP_BITS / DATA_W;
  localparam int MB0        = (IFG_BEATS > JAM_BEATS) ? IFG_BEATS : JAM_BEATS;
  localparam int MAXB       = (MB0 > BP_BEATS) ? MB0 : BP_BEATS;
  localparam int CNT_W      = $clog2(MAXB + 1);
  localparam int ATT_W      = $clog2(MAX_ATTEMPTS + 1);

  localparam logic [CNT_W-1:0] IFG_LD  = CNT_W'(IFG_BEATS - 1);
  localparam logic [CNT_W-1:0] JAM_LD  = CNT_W'(JAM_BEATS - 2); // collision cycle is jam beat 0
  localparam logic [CNT_W-1:0] BP_LAST = CNT_W'(BP_BEATS - 1);
  localparam logic [ATT_W-1:0] ATT_MAX = ATT_W'(MAX_ATTEMPTS);

  hdtx_state_e         state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ATT_W-1:0]    att_q;
  logic                ur_q;
  logic                crs_q;
  logic [DATA_W-1:0]   txd_q;
  logic                tx_en_q, tx_er_q;
  logic                done_q, xcol_q, urp_q;

  logic [BACKOFF_LIMIT-1:0] rnd;
  logic                     bo_start, bo_expire;
  logic [DATA_W-1:0]        bp_beat;
  logic                     jam_end;

  hdtx_lfsr #(
    .W     (LFSR_W),
    .TAPS  (LFSR_TAPS),
    .OUT_W (BACKOFF_LIMIT)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  hdtx_backoff #(
    .SLOT_BEATS (SLOT_BEATS),
    .LIMIT      (BACKOFF_LIMIT),
    .ATT_W      (ATT_W)
  ) u_backoff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (bo_start),
    .att_i    (att_q),
    .rnd_i    (rnd),
    .expire_o (bo_expire)
  );

  hdtx_pattern_mux #(
    .DATA_W  (DATA_W),
    .BITS    (BP_BITS),
    .PATTERN (BP_PATTERN),
    .IDX_W   (CNT_W)
  ) u_bp_mux (
    .idx_i  (cnt_q),
    .beat_o (bp_beat)
  );

  assign jam_end   = (state_q == ST_JAM) && (cnt_q == '0);
  assign bo_start  = jam_end && !ur_q && (att_q != ATT_MAX);
  assign data_rd_o = (state_q == ST_TX) && data_avail_i && !col_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      att_q   <= '0;
      ur_q    <= 1'b0;
      crs_q   <= 1'b0;
      txd_q   <= '0;
      tx_en_q <= 1'b0;
      tx_er_q <= 1'b0;
      done_q  <= 1'b0;
      xcol_q  <= 1'b0;
      urp_q   <= 1'b0;
    end else begin
      crs_q   <= crs_i;
      tx_en_q <= 1'b0;
      tx_er_q <= 1'b0;
      done_q  <= 1'b0;
      xcol_q  <= 1'b0;
      urp_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tx_req_i) begin
            att_q   <= '0;
            state_q <= ST_DEFER;
          end else if (bp_en_i && crs_i && !crs_q) begin
            cnt_q   <= '0;
            state_q <= ST_BP;
          end
        end
        ST_DEFER: begin
          if (!crs_i) begin
            cnt_q   <= IFG_LD;
            state_q <= ST_IFG;
          end
        end
        ST_IFG: begin
          if (crs_i)              state_q <= ST_DEFER;
          else if (cnt_q == '0)   state_q <= ST_TX;
          else                    cnt_q   <= cnt_q - 1'b1;
        end
        ST_TX: begin
          tx_en_q <= 1'b1;
          if (col_i || !data_avail_i) begin
            // data register is held: it becomes the jam content
            tx_er_q <= !col_i;
            ur_q    <= !col_i;
            if (col_i) att_q <= att_q + 1'b1;
            cnt_q   <= JAM_LD;
            state_q <= ST_JAM;
          end else begin
            txd_q <= data_i;
            if (data_last_i) begin
              done_q  <= 1'b1;
              att_q   <= '0;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_JAM: begin
          tx_en_q <= 1'b1;
          tx_er_q <= ur_q;
          if (cnt_q == '0) begin
            if (ur_q) begin
              urp_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (att_q == ATT_MAX) begin
              xcol_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_BACKOFF;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BACKOFF: begin
          if (bo_expire) state_q <= ST_DEFER;
        end
        ST_BP: begin
          tx_en_q <= 1'b1;
          txd_q   <= bp_beat;
          if (cnt_q == BP_LAST) state_q <= ST_IDLE;
          else                  cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign txd_o        = txd_q;
  assign tx_en_o      = tx_en_q;
  assign tx_er_o      = tx_er_q;
  assign done_o       = done_q;
  assign excess_col_o = xcol_q;
  assign underrun_o   = urp_q;
endmodule

// File: rtl/hdtx_mac_ctrl_chk.sv
module hdtx_mac_ctrl_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              crs_i,
  input logic              bp_en_i,
  input logic [DATA_W-1:0] txd_o,
  input logic              tx_en_o,
  input logic              tx_er_o,
  input logic              done_o,
  input logic              excess_col_o,
  input logic              underrun_o
);
  AST_ER_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_er_o |-> tx_en_o); // R8

  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, excess_col_o, underrun_o})); // R12

  AST_STATUS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || excess_col_o || underrun_o) |=> !(done_o || excess_col_o || underrun_o)); // R12

  AST_DONE_ON_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_en_o && !tx_er_o)); // R4

  AST_EXCESS_ON_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excess_col_o |-> (tx_en_o && !tx_er_o)); // R7

  AST_UNDERRUN_ON_ER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> tx_er_o); // R8

  AST_JAM_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_er_o && $past(tx_er_o)) |-> $stable(txd_o)); // R8

  AST_START_ON_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (!$past(crs_i, 2) || $past(bp_en_i, 2))); // R2
endmodule

bind hdtx_mac_ctrl hdtx_mac_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .crs_i        (crs_i),
  .bp_en_i      (bp_en_i),
  .txd_o        (txd_o),
  .tx_en_o      (tx_en_o),
  .tx_er_o      (tx_er_o),
  .done_o       (done_o),
  .excess_col_o (excess_col_o),
  .underrun_o   (underrun_o)
);

// File: tb/hdtx_mac_ctrl_bench.sv
module hdtx_mac_ctrl_bench;
  localparam int DW    = 4;
  localparam int IFGB  = 96;
  localparam int JAMB  = 32;
  localparam int SLOTB = 32;
  localparam int BPB   = 64;
  localparam int MAXA  = 16;
  localparam int LIM   = 3;
  localparam logic [BPB-1:0] BPPAT = 64'hA5C3_0F96_1E2D_7B48;
  localparam int I = IFGB / DW;
  localparam int J = JAMB / DW;
  localparam int S = SLOTB / DW;
  localparam int B = BPB / DW;

  logic          clk, rst_n;
  logic          tx_req, data_avail, data_last, data_rd;
  logic [DW-1:0] data, txd;
  logic          crs, col, bp_en;
  logic          tx_en, tx_er, done, xcol, urun;

  int  n_chk = 0;
  int  n_bad = 0;
  int  flen  = 10;
  int  ur_at = -1;
  bit  ended = 0;
  logic [7:0] idx;

  hdtx_mac_ctrl #(
    .DATA_W(DW), .IFG_BITS(IFGB), .JAM_BITS(JAMB), .SLOT_BITS(SLOTB),
    .BP_BITS(BPB), .BP_PATTERN(BPPAT), .MAX_ATTEMPTS(MAXA), .BACKOFF_LIMIT(LIM)
  ) u_hdtx_mac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tx_req_i(tx_req), .data_i(data),
    .data_avail_i(data_avail), .data_last_i(data_last), .data_rd_o(data_rd),
    .crs_i(crs), .col_i(col), .bp_en_i(bp_en), .txd_o(txd), .tx_en_o(tx_en),
    .tx_er_o(tx_er), .done_o(done), .excess_col_o(xcol), .underrun_o(urun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k * 7 + 3);
  endfunction

  // upstream buffer model: rewinds on collision or when no frame is pending
  assign data       = pat(int'(idx));
  assign data_avail = (int'(idx) != ur_at);
  assign data_last  = (int'(idx) == flen - 1);
  always @(posedge clk) begin
    if (!tx_req || col) idx <= '0;
    else if (data_rd)   idx <= idx + 8'd1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!tx_en && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic get_frame(input int len, input string req);
    for (int k = 0; k < len; k++) begin
      chk(tx_en && !tx_er && txd == pat(k), req, int'(txd), int'(pat(k)));
      chk(done == (k == len - 1), "R4 done", int'(done), int'(k == len - 1));
      if (k == len - 1) tx_req = 1'b0;
      @(negedge clk);
    end
    chk(!tx_en, "R4 end", int'(tx_en), 0);
  endtask

  task automatic collide_at(input int kv, input bit last);
    repeat (kv) @(negedge clk);
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    for (int j = 0; j < J; j++) begin
      chk(tx_en && !tx_er && txd == pat(kv), "R5 jam", int'(txd), int'(pat(kv)));
      chk(xcol == (last && j == J - 1), "R7 excess", int'(xcol), int'(last && j == J - 1));
      if (xcol) tx_req = 1'b0;
      @(negedge clk);
    end
    chk(!tx_en, "R5 jam length", int'(tx_en), 0);
  endtask

  task automatic measure_gap(input int n, input string req);
    int l, rs, win;
    l = 0;
    while (!tx_en && l < 5000) begin
      l++;
      @(negedge clk);
    end
    rs  = l - I - 2;
    win = (1 << ((n < LIM) ? n : LIM)) - 1;
    chk(rs >= 0 && (rs % S) == 0 && (rs / S) <= win, req, l, I + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; tx_req = 1'b0; crs = 1'b0; col = 1'b0; bp_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_en && !tx_er && !data_rd && !done && !xcol && !urun, "R1 in reset", int'(tx_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_en && !tx_er && !data_rd && !done && !xcol && !urun, "R1 after reset", int'(tx_en), 0);

    // R2: defer on busy medium, then full gap
    flen = 10; crs = 1'b1; tx_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!tx_en, "R2 defer", int'(tx_en), 0);
    end
    crs = 1'b0;
    wait_rise(n);
    chk(n == I + 2, "R2 gap", n, I + 2);
    get_frame(flen, "R4 data");
    repeat (5) @(negedge clk);

    // R2: from idle with quiet medium
    flen = 6; tx_req = 1'b1;
    wait_rise(n);
    chk(n == I + 3, "R2 idle start", n, I + 3);
    get_frame(flen, "R4 data");
    repeat (5) @(negedge clk);

    // R3: carrier inside the gap restarts it
    flen = 7; tx_req = 1'b1;
    repeat (8) @(negedge clk);
    crs = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_en, "R3 held", int'(tx_en), 0);
    crs = 1'b0;
    wait_rise(n);
    chk(n == I + 2, "R3 restart", n, I + 2);
    get_frame(flen, "R4 data");
    repeat (5) @(negedge clk);

    // R5/R6: one collision, then a clean retry
    flen = 10; tx_req = 1'b1;
    wait_rise(n);
    collide_at(2, 1'b0);
    measure_gap(1, "R6 gap n=1");
    get_frame(flen, "R4 retry data");
    repeat (5) @(negedge clk);

    // R7: every attempt collides
    flen = 20; tx_req = 1'b1;
    wait_rise(n);
    for (int a = 1; a <= MAXA; a++) begin
      collide_at(1, a == MAXA);
      if (a < MAXA) measure_gap(a, "R6 gap");
    end
    for (int i = 0; i < 80; i++) begin
      chk(!tx_en && !done, "R7 abandoned", int'(tx_en), 0);
      @(negedge clk);
    end

    // R11: each new frame starts its collision count at zero
    for (int f = 0; f < 6; f++) begin
      flen = 8; tx_req = 1'b1;
      wait_rise(n);
      collide_at(1, 1'b0);
      measure_gap(1, "R11 first window");
      get_frame(flen, "R4 data");
      repeat (4) @(negedge clk);
    end

    // R8: underrun ends the frame with the error line
    flen = 12; ur_at = 5; tx_req = 1'b1;
    wait_rise(n);
    for (int k = 0; k < 5; k++) begin
      chk(tx_en && !tx_er && txd == pat(k), "R8 head", int'(txd), int'(pat(k)));
      @(negedge clk);
    end
    for (int j = 0; j < J; j++) begin
      chk(tx_en && tx_er && txd == pat(4), "R8 bad tail", int'(txd), int'(pat(4)));
      chk(urun == (j == J - 1), "R8 pulse", int'(urun), int'(j == J - 1));
      if (urun) tx_req = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < 80; i++) begin
      chk(!tx_en && !done && !tx_er, "R8 no retry", int'(tx_en), 0);
      @(negedge clk);
    end
    ur_at = -1;

    // R9: forced collision pattern
    bp_en = 1'b1; crs = 1'b1;
    @(negedge clk);
    chk(!tx_en, "R9 latency", int'(tx_en), 0);
    for (int i = 0; i < B; i++) begin
      @(negedge clk);
      chk(tx_en && !tx_er && txd == BPPAT[i*DW +: DW], "R9 pattern", int'(txd),
          int'(BPPAT[i*DW +: DW]));
    end
    @(negedge clk);
    chk(!tx_en, "R9 length", int'(tx_en), 0);
    repeat (5) @(negedge clk);
    crs = 1'b0;
    repeat (5) @(negedge clk);

    // R10: disabled back pressure stays silent
    bp_en = 1'b0; crs = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(!tx_en, "R10 silent", int'(tx_en), 0);
    end
    crs = 1'b0;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule